// File: doc/BRIEF.md
# Byte-Enable Write Request Converter

This block sits between a memory-mapped master with a 128-bit data bus and a packet-oriented transmit path. It accepts one single-beat write at a time: a byte address, a 16-bit byte-enable vector, a burst count and the 128-bit data. From these it builds a memory write request. The request is one header beat, followed by as many payload beats as there are enabled dwords, one 32-bit dword per beat.

The header carries a dword-aligned start address and a dword length. It also carries two 4-bit byte-enable fields, one for the first dword of the request and one for the last. The length is trimmed to the span of dwords that hold enabled bytes. A write of a single byte therefore becomes a one-dword request that enables only that byte lane, wherever the lane sits in the beat. Enable vectors with holes, and bursts longer than one beat, are refused with a one-cycle error pulse. A write with no bytes enabled is acknowledged and dropped. Both sides use a valid/ready handshake.

Byte `i` of the beat is `wr_data[8*i +: 8]` and is enabled by `wr_be[i]`. Dword `k` is `wr_data[32*k +: 32]` and is enabled by `wr_be[4*k +: 4]`.

Top module: `bewr_converter`

## Requirements
- R1: The header beat (`pkt_is_hdr` = 1) carries `pkt_len` = (index of highest dword with any enable bit) − (index of lowest such dword) + 1.
- R2: `pkt_first_be` equals the 4 enable bits of the lowest active dword, with bit 0 for its lowest byte.
- R3: `pkt_last_be` equals the 4 enable bits of the highest active dword when `pkt_len` > 1, and 0000 when `pkt_len` = 1.
- R4: `pkt_addr` equals `wr_addr` with bits [1:0] cleared, plus 4 × (index of the lowest active dword).
- R5: After the header come exactly `pkt_len` beats with `pkt_is_hdr` = 0. They carry the active dwords in ascending address order, starting at the lowest, and `pkt_eop` = 1 only on the last of them.
- R6: A write with a single byte enabled, at any of the 16 lanes, produces a request of length 1 whose first byte-enable field has exactly the addressed lane set and whose address is that lane's dword.
- R7: A nonzero enable vector whose set bits are not one contiguous run produces no request. Instead `req_err` is 1 for exactly one cycle, in the cycle after acceptance.
- R8: A write whose `wr_burst` differs from 1 produces no request and a one-cycle `req_err` pulse in the cycle after acceptance.
- R9: A write with burst 1 and an all-zero enable vector is accepted in one cycle. It produces neither a request nor an error, and `wr_ready` is 1 again in the next cycle.
- R10: While `pkt_valid` = 1 and `pkt_ready` = 0, all `pkt_*` outputs hold their values.
- R11: The header beat appears in the cycle after a convertible write is accepted. `wr_ready` stays 0 from then until the cycle after the last payload beat is taken.
- R12: After reset, `wr_ready` = 1, `pkt_valid` = 0 and `req_err` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Converter can take a write |
| wr_addr | input | 32 | Byte address of the beat |
| wr_be | input | 16 | Byte enables, bit i for byte i |
| wr_burst | input | 4 | Burst count; only 1 is convertible |
| wr_data | input | 128 | Write data |
| pkt_valid | output | 1 | Output beat present |
| pkt_ready | input | 1 | Downstream takes the beat |
| pkt_is_hdr | output | 1 | 1 on the header beat, 0 on payload beats |
| pkt_addr | output | 32 | Dword-aligned request address |
| pkt_len | output | 3 | Request length in dwords |
| pkt_first_be | output | 4 | First-dword byte enables |
| pkt_last_be | output | 4 | Last-dword byte enables |
| pkt_dw | output | 32 | Payload dword (zero on header beat) |
| pkt_eop | output | 1 | Last payload beat of the request |
| req_err | output | 1 | One-cycle pulse: write refused |

## Verification
Every result of this block lies a fixed number of register stages from the accepting clock edge. The header beat, the error pulse and the return of `wr_ready` after an empty write all appear one edge after acceptance. Each payload beat appears one edge after the previous beat was taken. The bench drives inputs and samples outputs at falling edges, so each check falls exactly one clock after the event that caused it. When it stalls `pkt_ready`, it samples once more at the next falling edge to confirm that the beat held still.

// File: rtl/bewr_pkg.sv
package bewr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_DATA = 2'd2
  } conv_state_e;

endpackage

// File: rtl/bewr_span_decode.sv
module bewr_span_decode #(
  parameter int NDW  = 4,
  parameter int BEW  = NDW * 4,
  parameter int IDXW = (NDW > 1) ? $clog2(NDW) : 1,
  parameter int LENW = $clog2(NDW + 1)
) (
  input  logic [BEW-1:0]  be,
  output logic            be_empty,
  output logic            be_contig,
  output logic [IDXW-1:0] lo_idx,
  output logic [IDXW-1:0] hi_idx,
  output logic [LENW-1:0] span_len,
  output logic [3:0]      lo_nib,
  output logic [3:0]      hi_nib
);

  logic [NDW-1:0] dw_active;

  for (genvar k = 0; k < NDW; k++) begin : g_act
    assign dw_active[k] = |be[4*k +: 4];
  end

  // A run is contiguous when adding its lowest set bit clears the whole run.
  function automatic logic f_contig(input logic [BEW-1:0] v);
    logic [BEW:0] x;
    logic [BEW:0] low;
    logic [BEW:0] sum;
    x   = {1'b0, v};
    low = x & (~x + {{BEW{1'b0}}, 1'b1});
    sum = x + low;
    return (sum & x) == '0;
  endfunction

  function automatic logic [IDXW-1:0] f_lowest(input logic [NDW-1:0] a);
    logic [IDXW-1:0] r;
    r = '0;
    for (int i = NDW - 1; i >= 0; i--) begin
      if (a[i]) r = IDXW'(i);
    end
    return r;
  endfunction

  function automatic logic [IDXW-1:0] f_highest(input logic [NDW-1:0] a);
    logic [IDXW-1:0] r;
    r = '0;
    for (int i = 0; i < NDW; i++) begin
      if (a[i]) r = IDXW'(i);
    end
    return r;
  endfunction

  always_comb begin
    be_empty  = (be == '0);
    be_contig = f_contig(be);
    lo_idx    = f_lowest(dw_active);
    hi_idx    = f_highest(dw_active);
    span_len  = LENW'(hi_idx) - LENW'(lo_idx) + LENW'(1);
    lo_nib    = be[4*lo_idx +: 4];
    hi_nib    = be[4*hi_idx +: 4];
  end

endmodule

// File: rtl/bewr_hdr_build.sv
module bewr_hdr_build #(
  parameter int AW   = 32,
  parameter int IDXW = 2,
  parameter int LENW = 3
) (
  input  logic [AW-1:0]   beat_addr,
  input  logic [IDXW-1:0] lo_idx,
  input  logic [LENW-1:0] span_len,
  input  logic [3:0]      lo_nib,
  input  logic [3:0]      hi_nib,
  output logic [AW-1:0]   req_addr,
  output logic [3:0]      first_be,
  output logic [3:0]      last_be
);

  function automatic logic [AW-1:0] f_dw_addr(input logic [AW-1:0] a,
                                               input logic [IDXW-1:0] idx);
    logic [AW-1:0] base;
    base = {a[AW-1:2], 2'b00};
    return base + (AW'(idx) << 2);
  endfunction

  always_comb begin
    req_addr = f_dw_addr(beat_addr, lo_idx);
    first_be = lo_nib;
    last_be  = (span_len == LENW'(1)) ? 4'b0000 : hi_nib;
  end

endmodule

// File: rtl/bewr_dw_select.sv
module bewr_dw_select #(
  parameter int NDW  = 4,
  parameter int IDXW = 2
) (
  input  logic [NDW*32-1:0] beat,
  input  logic [IDXW-1:0]   idx,
  output logic [31:0]       dw
);

  logic [31:0] lanes [NDW];

  for (genvar k = 0; k < NDW; k++) begin : g_lane
    assign lanes[k] = beat[32*k +: 32];
  end

  assign dw = lanes[idx];

endmodule

// File: rtl/bewr_converter.sv
module bewr_converter
  import bewr_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DBW = 128,
  parameter int BCW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DBW/8-1:0] wr_be,
  input  logic [BCW-1:0]   wr_burst,
  input  logic [DBW-1:0]   wr_data,
  output logic             pkt_valid,
  input  logic             pkt_ready,
  output logic             pkt_is_hdr,
  output logic [AW-1:0]    pkt_addr,
  output logic [$clog2(DBW/32+1)-1:0] pkt_len,
  output logic [3:0]       pkt_first_be,
  output logic [3:0]       pkt_last_be,
  output logic [31:0]      pkt_dw,
  output logic             pkt_eop,
  output logic             req_err
);

  localparam int NDW  = DBW / 32;
  localparam int BEW  = DBW / 8;
  localparam int IDXW = (NDW > 1) ? $clog2(NDW) : 1;
  localparam int LENW = $clog2(NDW + 1);

  conv_state_e state_q, state_d;

  // decode of the incoming beat
  logic            be_empty, be_contig;
  logic [IDXW-1:0] lo_idx, hi_idx;
  logic [LENW-1:0] span_len;
  logic [3:0]      lo_nib, hi_nib;
  logic [AW-1:0]   hb_addr;
  logic [3:0]      hb_first, hb_last;

  // captured request
  logic [DBW-1:0]  data_q;
  logic [IDXW-1:0] lo_q;
  logic [LENW-1:0] len_q;
  logic [LENW-1:0] cnt_q;
  logic [AW-1:0]   addr_q;
  logic [3:0]      first_q, last_q;
  logic            err_q;
  logic [31:0]     sel_dw;

  // named events
  logic ev_accept, ev_burst_ok, ev_convert, ev_refuse, ev_take, ev_last_beat;

  bewr_span_decode #(
    .NDW (NDW), .BEW (BEW), .IDXW (IDXW), .LENW (LENW)
  ) u_decode (
    .be        (wr_be),
    .be_empty  (be_empty),
    .be_contig (be_contig),
    .lo_idx    (lo_idx),
    .hi_idx    (hi_idx),
    .span_len  (span_len),
    .lo_nib    (lo_nib),
    .hi_nib    (hi_nib)
  );

  bewr_hdr_build #(
    .AW (AW), .IDXW (IDXW), .LENW (LENW)
  ) u_hdr (
    .beat_addr (wr_addr),
    .lo_idx    (lo_idx),
    .span_len  (span_len),
    .lo_nib    (lo_nib),
    .hi_nib    (hi_nib),
    .req_addr  (hb_addr),
    .first_be  (hb_first),
    .last_be   (hb_last)
  );

  bewr_dw_select #(
    .NDW (NDW), .IDXW (IDXW)
  ) u_sel (
    .beat (data_q),
    .idx  (lo_q + IDXW'(cnt_q)),
    .dw   (sel_dw)
  );

  assign wr_ready     = (state_q == ST_IDLE);
  assign ev_accept    = wr_valid && wr_ready;
  assign ev_burst_ok  = (wr_burst == BCW'(1));
  assign ev_convert   = ev_accept && ev_burst_ok && !be_empty && be_contig;
  assign ev_refuse    = ev_accept && (!ev_burst_ok || (!be_empty && !be_contig));
  assign ev_take      = pkt_valid && pkt_ready;
  assign ev_last_beat = (state_q == ST_DATA) && (cnt_q == len_q - LENW'(1));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (ev_convert) state_d = ST_HDR;
      ST_HDR:  if (ev_take)    state_d = ST_DATA;
      ST_DATA: if (ev_take && ev_last_beat) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      data_q  <= '0;
      lo_q    <= '0;
      len_q   <= '0;
      cnt_q   <= '0;
      addr_q  <= '0;
      first_q <= '0;
      last_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= ev_refuse;
      if (ev_convert) begin
        data_q  <= wr_data;
        lo_q    <= lo_idx;
        len_q   <= span_len;
        addr_q  <= hb_addr;
        first_q <= hb_first;
        last_q  <= hb_last;
        cnt_q   <= '0;
      end else if (state_q == ST_DATA && ev_take && !ev_last_beat) begin
        cnt_q <= cnt_q + LENW'(1);
      end
    end
  end

  assign pkt_valid    = (state_q != ST_IDLE);
  assign pkt_is_hdr   = (state_q == ST_HDR);
  assign pkt_addr     = addr_q;
  assign pkt_len      = len_q;
  assign pkt_first_be = first_q;
  assign pkt_last_be  = last_q;
  assign pkt_dw       = (state_q == ST_DATA) ? sel_dw : 32'h0;
  assign pkt_eop      = ev_last_beat;
  assign req_err      = err_q;

  // assertions
  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> wr_ready && !pkt_valid && !req_err); // R12

  AST_HDR_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_convert |=> pkt_valid && pkt_is_hdr); // R11

  AST_BUSY_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> !wr_ready); // R11

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && !pkt_ready |=> pkt_valid && $stable(pkt_is_hdr) && $stable(pkt_dw)
      && $stable(pkt_addr) && $stable(pkt_len) && $stable(pkt_eop)); // R10

  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_is_hdr |-> pkt_len >= LENW'(1) && pkt_len <= LENW'(NDW)); // R1

  AST_FIRST_BE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_is_hdr |-> pkt_first_be != 4'b0000); // R2

  AST_LAST_BE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_is_hdr && pkt_len == LENW'(1) |-> pkt_last_be == 4'b0000); // R3

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> pkt_addr[1:0] == 2'b00); // R4

  AST_EOP_ON_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_eop |-> pkt_valid && !pkt_is_hdr); // R5

  AST_EOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_eop && pkt_ready |=> !pkt_valid); // R5

  AST_ERR_NO_PKT: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> !pkt_valid && wr_ready); // R7

  AST_ERR_FROM_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_refuse |=> req_err); // R8

endmodule

// File: tb/tb_bewr_converter.sv
`timescale 1ns/1ps
module tb_bewr_converter;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_valid = 1'b0;
  logic         wr_ready;
  logic [31:0]  wr_addr = '0;
  logic [15:0]  wr_be = '0;
  logic [3:0]   wr_burst = 4'd1;
  logic [127:0] wr_data = '0;
  logic         pkt_valid;
  logic         pkt_ready = 1'b1;
  logic         pkt_is_hdr;
  logic [31:0]  pkt_addr;
  logic [2:0]   pkt_len;
  logic [3:0]   pkt_first_be, pkt_last_be;
  logic [31:0]  pkt_dw;
  logic         pkt_eop;
  logic         req_err;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  bewr_converter dut (
    .clk (clk), .rst_n (rst_n),
    .wr_valid (wr_valid), .wr_ready (wr_ready), .wr_addr (wr_addr),
    .wr_be (wr_be), .wr_burst (wr_burst), .wr_data (wr_data),
    .pkt_valid (pkt_valid), .pkt_ready (pkt_ready), .pkt_is_hdr (pkt_is_hdr),
    .pkt_addr (pkt_addr), .pkt_len (pkt_len), .pkt_first_be (pkt_first_be),
    .pkt_last_be (pkt_last_be), .pkt_dw (pkt_dw), .pkt_eop (pkt_eop),
    .req_err (req_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Byte-walk reference: locate first/last enabled byte and count them.
  task automatic run_write(input logic [31:0] a, input logic [15:0] be,
                           input logic [3:0] burst, input logic [127:0] d,
                           input bit stall);
    int first_b = -1, last_b = -1, ones = 0;
    int lo, hi, len;
    bit contig;
    logic [3:0] e_first, e_last;
    logic [31:0] e_addr;
    for (int i = 0; i < 16; i++) begin
      if (be[i]) begin
        if (first_b < 0) first_b = i;
        last_b = i;
        ones++;
      end
    end
    contig = (ones == 0) || (ones == last_b - first_b + 1);
    pkt_ready = !stall;
    @(negedge clk);
    chk(wr_ready === 1'b1, "R11 idle ready", 32'(wr_ready), 1);
    wr_valid = 1'b1; wr_addr = a; wr_be = be; wr_burst = burst; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    if (burst != 4'd1 || !contig) begin
      chk(req_err === 1'b1, (burst != 4'd1) ? "R8 err pulse" : "R7 err pulse",
          32'(req_err), 1);
      chk(pkt_valid === 1'b0, "R7 no packet", 32'(pkt_valid), 0);
      @(negedge clk);
      chk(req_err === 1'b0, "R7 pulse one cycle", 32'(req_err), 0);
      chk(pkt_valid === 1'b0, "R8 no packet", 32'(pkt_valid), 0);
      return;
    end
    if (ones == 0) begin
      chk(pkt_valid === 1'b0, "R9 no packet", 32'(pkt_valid), 0);
      chk(req_err === 1'b0, "R9 no error", 32'(req_err), 0);
      chk(wr_ready === 1'b1, "R9 ready again", 32'(wr_ready), 1);
      return;
    end
    lo = first_b / 4; hi = last_b / 4; len = hi - lo + 1;
    e_first = be[4*lo +: 4];
    e_last  = (len == 1) ? 4'b0 : be[4*hi +: 4];
    e_addr  = {a[31:2], 2'b00} + 32'(4 * lo);
    chk(pkt_valid === 1'b1 && pkt_is_hdr === 1'b1, "R11 header next cycle",
        {30'b0, pkt_valid, pkt_is_hdr}, 3);
    chk(wr_ready === 1'b0, "R11 busy", 32'(wr_ready), 0);
    if (stall) begin
      @(negedge clk);
      chk(pkt_valid === 1'b1 && pkt_is_hdr === 1'b1, "R10 header held",
          {30'b0, pkt_valid, pkt_is_hdr}, 3);
      pkt_ready = 1'b1;
    end
    chk(pkt_len === 3'(len), "R1 length", 32'(pkt_len), 32'(len));
    chk(pkt_first_be === e_first, "R2 first be", 32'(pkt_first_be), 32'(e_first));
    chk(pkt_last_be === e_last, "R3 last be", 32'(pkt_last_be), 32'(e_last));
    chk(pkt_addr === e_addr, "R4 address", pkt_addr, e_addr);
    if (ones == 1)
      chk(pkt_len == 3'd1 && pkt_first_be == (4'b1 << (first_b % 4)),
          "R6 single byte lane", {25'b0, pkt_len, pkt_first_be},
          {25'b0, 3'd1, 4'b1 << (first_b % 4)});
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      chk(pkt_valid === 1'b1 && pkt_is_hdr === 1'b0, "R5 data beat",
          {30'b0, pkt_valid, pkt_is_hdr}, 2);
      chk(pkt_dw === d[32*(lo+k) +: 32], "R5 payload order", pkt_dw, d[32*(lo+k) +: 32]);
      chk(pkt_eop === (k == len - 1), "R5 eop", 32'(pkt_eop), 32'(k == len - 1));
      chk(wr_ready === 1'b0, "R11 busy data", 32'(wr_ready), 0);
      if (stall && k == 0) begin
        pkt_ready = 1'b0;
        @(negedge clk);
        chk(pkt_dw === d[32*lo +: 32] && pkt_is_hdr === 1'b0, "R10 data held",
            pkt_dw, d[32*lo +: 32]);
        pkt_ready = 1'b1;
      end
    end
    @(negedge clk);
    chk(pkt_valid === 1'b0 && wr_ready === 1'b1, "R11 ready after eop",
        {30'b0, pkt_valid, wr_ready}, 1);
  endtask

  localparam logic [127:0] PAT = 128'hF00DCAFE_33445566_89ABCDEF_01234567;

  task automatic t_reset();
    chk(wr_ready === 1'b1, "R12 ready", 32'(wr_ready), 1);
    chk(pkt_valid === 1'b0, "R12 pkt_valid", 32'(pkt_valid), 0);
    chk(req_err === 1'b0, "R12 req_err", 32'(req_err), 0);
  endtask

  task automatic t_dword_patterns();
    logic [15:0] pats [10] = '{16'h000F, 16'h00F0, 16'h0F00, 16'hF000, 16'h00FF,
                              16'h0FF0, 16'hFF00, 16'h0FFF, 16'hFFF0, 16'hFFFF};
    foreach (pats[i]) run_write(32'h1000_0000, pats[i], 4'd1, PAT, 1'b0); // R1 R2 R3 R5
  endtask

  task automatic t_sub_dword();
    run_write(32'h2000_0010, 16'h0001, 4'd1, PAT, 1'b0); // R3
    run_write(32'h2000_0010, 16'h0003, 4'd1, PAT, 1'b0);
    run_write(32'h2000_0010, 16'h0007, 4'd1, PAT, 1'b0);
    run_write(32'h2000_0010, 16'h0180, 4'd1, PAT, 1'b0); // straddles two dwords
    run_write(32'h2000_0010, 16'h3FFC, 4'd1, PAT, 1'b0);
  endtask

  task automatic t_single_bytes();
    for (int i = 0; i < 16; i++)
      run_write(32'h3000_0020 + 32'(i), 16'h1 << i, 4'd1, PAT ^ 128'(i), 1'b0); // R6 R4
  endtask

  task automatic t_refused();
    run_write(32'h4000_0000, 16'h0005, 4'd1, PAT, 1'b0); // R7
    run_write(32'h4000_0000, 16'hF0F0, 4'd1, PAT, 1'b0); // R7
    run_write(32'h4000_0000, 16'h00FF, 4'd2, PAT, 1'b0); // R8
  endtask

  task automatic t_zero();
    run_write(32'h5000_0000, 16'h0000, 4'd1, PAT, 1'b0); // R9
    run_write(32'h5000_0040, 16'h0FF0, 4'd1, ~PAT, 1'b0); // follows at once
  endtask

  task automatic t_stall();
    run_write(32'h6000_0000, 16'hFFF8, 4'd1, PAT, 1'b1); // R10
    run_write(32'h6000_0000, 16'h0100, 4'd1, PAT, 1'b1); // R10
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_dword_patterns();
    t_sub_dword();
    t_single_bytes();
    t_refused();
    t_zero();
    t_stall();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule